// File: doc/BRIEF.md
# Prescaled Free-Running Time Base

This block is a 16-bit up-counter that runs without stopping from the system clock. A divider sits in front of it and lets the count advance once every 1, 4, 8 or 16 clock cycles. The count serves as the common time reference for the compare and capture channels built around it. Those channels read the count value. They also see a one-cycle tick that marks each cycle in which the count will step, so they can sample in step with it.

Software sets the division ratio through a select register. That register takes only the first write, and only if the write lands within the first 64 clock edges after reset; every later write is dropped. Software has no way to load the count. When the count wraps from all ones to zero, a status flag is set. Software clears the flag by writing a one to it. An enable bit decides whether the flag also drives the interrupt request output or whether software has to poll the flag.

Top module: `frc_timebase`

## Requirements
- R1: While reset is asserted and at release, the count is 0, the overflow flag, the interrupt enable and the interrupt request are 0, and the prescale select reads 00.
- R2: The count rises by exactly one on each clock edge at which `tick_o` is high and holds on every other edge; no input loads it.
- R3: The prescale select code gives the division ratio: 00 for every cycle, 01 for every 4th, 10 for every 8th and 11 for every 16th.
- R4: A prescale write is taken only on clock edges 0 to 63 counted from reset release; a write on edge 64 or later leaves the select unchanged.
- R5: Only the first prescale write inside the window is taken; a second write inside the window is dropped.
- R6: The edge on which a tick meets a count of 0xFFFF sets the count to 0x0000 and sets the overflow flag.
- R7: A flag-clear write with data 1 clears the overflow flag; a flag-clear write with data 0 leaves it set.
- R8: When a wrap and a flag clear with data 1 fall on the same edge, the flag ends up set.
- R9: `irq_o` is high exactly when the overflow flag and the interrupt enable are both set; `ie_wr` loads the enable from `ie_wdata`.
- R10: `tick_o` is high for one cycle before each count step; with divide-by-1 it stays high, and after a write that selects a new ratio the divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, deasserts in step with clk |
| psel_wr | input | 1 | Write strobe for the prescale select |
| psel_wdata | input | 2 | Prescale select code to be written |
| ie_wr | input | 1 | Write strobe for the overflow interrupt enable |
| ie_wdata | input | 1 | Value to be written to the interrupt enable |
| clr_wr | input | 1 | Write strobe for the overflow status bit |
| clr_wdata | input | 1 | A 1 clears the overflow flag; a 0 leaves it alone |
| count_o | output | 16 | Current count value |
| tick_o | output | 1 | High in the cycle before the count steps |
| psel_o | output | 2 | Prescale select currently in force |
| ovf_flag_o | output | 1 | Overflow status flag |
| ovf_ie_o | output | 1 | Overflow interrupt enable |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The properties assume three things about the inputs. Reset is released in step with the clock. Each write strobe is a full-cycle level that is seen at exactly one rising edge. The clear data is ignored whenever the clear strobe is low. The bench drives every strobe and every data value on the falling edge and drops each strobe after one cycle, so no write is ever seen twice. It reads the outputs only on falling edges, so each edge-counted expectation for the 64-edge window and the divider phase matches a well-defined number of rising edges since reset.

// File: rtl/frc_pkg.sv
package frc_pkg;

  localparam int FRC_SEL_W = 2;
  localparam int FRC_DIV_W = 4;

  typedef enum logic [FRC_SEL_W-1:0] {
    DIV_BY_1  = 2'b00,
    DIV_BY_4  = 2'b01,
    DIV_BY_8  = 2'b10,
    DIV_BY_16 = 2'b11
  } frc_div_e;

  // Terminal value of the divider phase counter for a select code.
  function automatic logic [FRC_DIV_W-1:0] frc_div_limit(input logic [FRC_SEL_W-1:0] sel);
    unique case (frc_div_e'(sel))
      DIV_BY_1:  frc_div_limit = FRC_DIV_W'(0);
      DIV_BY_4:  frc_div_limit = FRC_DIV_W'(3);
      DIV_BY_8:  frc_div_limit = FRC_DIV_W'(7);
      default:   frc_div_limit = FRC_DIV_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/frc_sel_lock.sv
// Holds the prescale select; accepts one write inside an early window.
module frc_sel_lock
  import frc_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [FRC_SEL_W-1:0] wdata_i,
  output logic [FRC_SEL_W-1:0] sel_o,
  output logic                 take_o
);

  localparam int WIN_W = $clog2(LOCK_CYCLES + 1);

  logic [WIN_W-1:0]     win_q, win_d;
  logic                 used_q, used_d;
  logic [FRC_SEL_W-1:0] sel_q, sel_d;
  logic                 win_open;
  logic                 win_en;

  assign win_open = (win_q < WIN_W'(LOCK_CYCLES)) && !used_q;
  assign take_o   = wr_i && win_open;
  assign win_en   = (win_q < WIN_W'(LOCK_CYCLES));

  always_comb begin
    win_d  = win_q;
    used_d = used_q;
    sel_d  = sel_q;
    if (win_en) begin
      win_d = win_q + WIN_W'(1);
    end
    if (take_o) begin
      used_d = 1'b1;
      sel_d  = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      used_q <= 1'b0;
      sel_q  <= DIV_BY_1;
    end else begin
      win_q  <= win_d;
      used_q <= used_d;
      sel_q  <= sel_d;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/frc_divider.sv
// Phase counter that yields one tick per selected number of cycles.
module frc_divider
  import frc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FRC_SEL_W-1:0] sel_i,
  input  logic                 restart_i,
  output logic                 tick_o
);

  logic [FRC_DIV_W-1:0] ph_q, ph_d;
  logic [FRC_DIV_W-1:0] limit;

  assign limit  = frc_div_limit(sel_i);
  assign tick_o = (ph_q >= limit);

  always_comb begin
    if (restart_i || tick_o) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + FRC_DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/frc_counter.sv
// Free-running up-counter with a clock enable; flags the wrap edge.
module frc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap_o = en_i && (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/frc_ovf_status.sv
// Overflow flag (write-one-to-clear, set wins) and interrupt gating.
module frc_ovf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic clr_wr_i,
  input  logic clr_wdata_i,
  input  logic ie_wr_i,
  input  logic ie_wdata_i,
  output logic flag_o,
  output logic ie_o,
  output logic irq_o
);

  logic flag_q, flag_d;
  logic ie_q, ie_d;

  always_comb begin
    flag_d = flag_q;
    if (wrap_i) begin
      flag_d = 1'b1;
    end else if (clr_wr_i && clr_wdata_i) begin
      flag_d = 1'b0;
    end
    ie_d = ie_q;
    if (ie_wr_i) begin
      ie_d = ie_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign irq_o  = flag_q && ie_q;

endmodule

// File: rtl/frc_timebase.sv
module frc_timebase
  import frc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOCK_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel_wr,
  input  logic [FRC_SEL_W-1:0] psel_wdata,
  input  logic                 ie_wr,
  input  logic                 ie_wdata,
  input  logic                 clr_wr,
  input  logic                 clr_wdata,
  output logic [CNT_W-1:0]     count_o,
  output logic                 tick_o,
  output logic [FRC_SEL_W-1:0] psel_o,
  output logic                 ovf_flag_o,
  output logic                 ovf_ie_o,
  output logic                 irq_o
);

  logic [FRC_SEL_W-1:0] sel;
  logic                 sel_take;
  logic                 tick;
  logic                 wrap;

  frc_sel_lock #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_sel_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (psel_wr),
    .wdata_i (psel_wdata),
    .sel_o   (sel),
    .take_o  (sel_take)
  );

  frc_divider u_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel),
    .restart_i (sel_take),
    .tick_o    (tick)
  );

  frc_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (tick),
    .count_o (count_o),
    .wrap_o  (wrap)
  );

  frc_ovf_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrap_i      (wrap),
    .clr_wr_i    (clr_wr),
    .clr_wdata_i (clr_wdata),
    .ie_wr_i     (ie_wr),
    .ie_wdata_i  (ie_wdata),
    .flag_o      (ovf_flag_o),
    .ie_o        (ovf_ie_o),
    .irq_o       (irq_o)
  );

  assign tick_o = tick;
  assign psel_o = sel;

endmodule

// File: rtl/frc_timebase_chk.sv
module frc_timebase_chk #(
  parameter int CNT_W       = 16,
  parameter int LOCK_CYCLES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_wr,
  input logic             clr_wdata,
  input logic [CNT_W-1:0] count_o,
  input logic             tick_o,
  input logic [1:0]       psel_o,
  input logic             ovf_flag_o,
  input logic             ovf_ie_o,
  input logic             irq_o
);

  localparam int CYC_W = $clog2(LOCK_CYCLES + 2);

  logic [CYC_W-1:0] cyc_q;
  logic             at_top;
  logic             clr1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q <= CYC_W'(LOCK_CYCLES)) begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign at_top = tick_o && (count_o == {CNT_W{1'b1}});
  assign clr1   = clr_wr && clr_wdata;

  AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> (count_o == '0 && !ovf_flag_o && !ovf_ie_o && !irq_o && psel_o == 2'b00)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) tick_o |=> (count_o == $past(count_o) + CNT_W'(1))); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick_o |=> $stable(count_o)); // R2
  AST_DIV1_TICK: assert property (@(posedge clk) disable iff (!rst_n) (psel_o == 2'b00) |-> tick_o); // R3
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (cyc_q >= CYC_W'(LOCK_CYCLES)) |=> $stable(psel_o)); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) at_top |=> (ovf_flag_o && count_o == '0)); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n) (clr1 && !at_top) |=> !ovf_flag_o); // R7
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag_o && !clr1) |=> ovf_flag_o); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (ovf_flag_o && ovf_ie_o)); // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag_o && ovf_ie_o) |-> irq_o); // R9

endmodule

bind frc_timebase frc_timebase_chk #(
  .CNT_W       (CNT_W),
  .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_wr     (clr_wr),
  .clr_wdata  (clr_wdata),
  .count_o    (count_o),
  .tick_o     (tick_o),
  .psel_o     (psel_o),
  .ovf_flag_o (ovf_flag_o),
  .ovf_ie_o   (ovf_ie_o),
  .irq_o      (irq_o)
);

// File: tb/frc_timebase_tb.sv
module frc_timebase_tb;

  logic        clk;
  logic        rst_n;
  logic        psel_wr;
  logic [1:0]  psel_wdata;
  logic        ie_wr;
  logic        ie_wdata;
  logic        clr_wr;
  logic        clr_wdata;
  logic [15:0] count_o;
  logic        tick_o;
  logic [1:0]  psel_o;
  logic        ovf_flag_o;
  logic        ovf_ie_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Entry: [31:30] select code, [29:16] edges after the write edge, [15:0] expected count.
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {2'b00, 14'd10, 16'd11},
    {2'b00, 14'd0,  16'd1},
    {2'b01, 14'd3,  16'd1},
    {2'b01, 14'd4,  16'd2},
    {2'b01, 14'd10, 16'd3},
    {2'b10, 14'd8,  16'd2},
    {2'b10, 14'd20, 16'd3},
    {2'b11, 14'd15, 16'd1},
    {2'b11, 14'd16, 16'd2},
    {2'b11, 14'd48, 16'd4}
  };

  frc_timebase u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel_wr    (psel_wr),
    .psel_wdata (psel_wdata),
    .ie_wr      (ie_wr),
    .ie_wdata   (ie_wdata),
    .clr_wr     (clr_wr),
    .clr_wdata  (clr_wdata),
    .count_o    (count_o),
    .tick_o     (tick_o),
    .psel_o     (psel_o),
    .ovf_flag_o (ovf_flag_o),
    .ovf_ie_o   (ovf_ie_o),
    .irq_o      (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_sel(input logic [1:0] code);
    psel_wr    = 1'b1;
    psel_wdata = code;
    @(negedge clk);
    psel_wr = 1'b0;
  endtask

  task automatic write_ie(input logic v);
    ie_wr    = 1'b1;
    ie_wdata = v;
    @(negedge clk);
    ie_wr = 1'b0;
  endtask

  task automatic write_clr(input logic v);
    clr_wr    = 1'b1;
    clr_wdata = v;
    @(negedge clk);
    clr_wr = 1'b0;
  endtask

  task automatic run_to_top();
    for (int g = 0; g < 70000 && count_o != 16'hFFFF; g++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    psel_wr = 0; psel_wdata = 0; ie_wr = 0; ie_wdata = 0; clr_wr = 0; clr_wdata = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 count in reset", count_o, 0);
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 flag", ovf_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 enable", ovf_ie_o, 0);
    chk("R1 select", psel_o, 0);
    chk("R10 tick div1", tick_o, 1);

    // R3 table walk: write on edge 0, which also steps the count once.
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      write_sel(VEC[i][31:30]);
      repeat (int'(VEC[i][29:16])) @(negedge clk);
      chk($sformatf("R3 vector %0d count", i), count_o, int'(VEC[i][15:0]));
      chk($sformatf("R3 vector %0d select", i), psel_o, int'(VEC[i][31:30]));
    end

    // R10 tick phase with divide-by-4
    do_reset();
    write_sel(2'b01);
    chk("R10 tick phase0", tick_o, 0);
    repeat (2) @(negedge clk);
    chk("R10 tick phase2", tick_o, 0);
    @(negedge clk);
    chk("R10 tick phase3", tick_o, 1);
    chk("R2 count before step", count_o, 1);
    @(negedge clk);
    chk("R2 count after step", count_o, 2);
    chk("R10 tick drops", tick_o, 0);

    // R4 last edge in window accepted
    do_reset();
    repeat (63) @(negedge clk);
    write_sel(2'b11);
    chk("R4 edge 63 accepted", psel_o, 3);

    // R4 first edge after window dropped
    do_reset();
    repeat (64) @(negedge clk);
    write_sel(2'b10);
    chk("R4 edge 64 dropped", psel_o, 0);
    chk("R4 count still div1", count_o, 65);

    // R5 second write dropped
    do_reset();
    write_sel(2'b01);
    write_sel(2'b11);
    chk("R5 second write dropped", psel_o, 1);

    // R6, R7, R8, R9 overflow behaviour with divide-by-1
    do_reset();
    run_to_top();
    chk("R6 count at top", count_o, 16'hFFFF);
    chk("R6 flag before wrap", ovf_flag_o, 0);
    @(negedge clk);
    chk("R6 count wrapped", count_o, 0);
    chk("R6 flag set", ovf_flag_o, 1);
    chk("R9 irq masked", irq_o, 0);
    write_ie(1'b1);
    chk("R9 irq enabled", irq_o, 1);
    write_clr(1'b0);
    chk("R7 zero write keeps flag", ovf_flag_o, 1);
    write_clr(1'b1);
    chk("R7 one write clears flag", ovf_flag_o, 0);
    chk("R9 irq follows flag", irq_o, 0);
    run_to_top();
    write_clr(1'b1);
    chk("R8 set wins", ovf_flag_o, 1);
    chk("R8 count wrapped", count_o, 0);
    chk("R9 irq on set", irq_o, 1);
    write_ie(1'b0);
    chk("R9 irq off with enable low", irq_o, 0);
    chk("R9 flag kept", ovf_flag_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule